// File: doc/BRIEF.md
# TDM Transmit Slot Sequencer

This block builds the transmit side of a channelised TDM link from a programmable slot table. Once a frame sync arrives, it reads the table from entry 0 onward, one TDM bit per clock. Each entry covers a run of bits or bytes on the line. An entry either fills its run from one of up to 256 per-channel transmit FIFOs or leaves the run unsourced, in which case the run is sent as ones. The walk stops after the entry flagged as last. The line then idles high until the next frame sync.

A single entry can take two consecutive bytes from one FIFO (the 16-bit super-channel form). This halves the number of entries and channels needed for each multiplexed E1. A clear 30-octet payload then fits in 16 channels: seven 2-byte entries plus one 1-byte entry for each half. A second table maps every channel to a root channel, so the stream owner can be identified with each FIFO pop. If a FIFO is empty when its byte is due, the block sends ones for that byte and reports an underrun for that channel.

Both tables are loaded through one write port while the sequencer is disabled.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: Slot entry layout. Bit 0 is source enable, bit 1 is loop, bit 2 is super-channel and bits 10:3 are the channel. Bits 13:11 hold a count c, bit 14 is the unit (1 = bytes, 0 = bits) and bit 15 is last. An entry covers c+1 units on the line.
- R2: A sourced entry pops one byte from its channel's FIFO at its first bit and again every 8 bits after that. Each byte is sent MSB first. Bits still unsent when the entry ends are dropped.
- R3: An entry with source enable clear drives ones for its whole run and pops nothing.
- R4: The walk stops after the entry with last set, or after the final table entry. The line then stays at ones until a frame sync, and each frame restarts at entry 0.
- R5: A frame sync sampled while enabled restarts the walk at entry 0, even in mid-walk. `tdm_sync_o` is high with the first bit of the frame, two clocks after the sync is sampled.
- R6: With super-channel set, `pop_root_o` is the root-map value for the channel. Otherwise it is the channel itself. Writes with `wr_sel_i`=1 load the root map and writes with `wr_sel_i`=0 load the slot table.
- R7: If the FIFO is empty when a byte is due, the block does not pop, sends that byte as ones and raises `underrun_o` with the channel on `underrun_ch_o` one clock later.
- R8: Writes to either table are ignored while `enable_i` is high.
- R9: While `enable_i` is low, all outputs idle (line and loop outputs at ones, no pops, no sync). The walk stays stopped after re-enable until a frame sync arrives.
- R10: After reset, `tdm_tx_o` and `tdm_loop_o` are 1, and `tdm_sync_o`, `pop_o` and `underrun_o` are 0.
- R11: An entry with super-channel set, unit bytes and count 1 pops two consecutive bytes from the same FIFO.
- R12: While an entry has loop set, its bits go to `tdm_loop_o` and `tdm_tx_o` carries ones. For all other entries `tdm_loop_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Sequencer enable; table writes are taken only while low |
| fsync_i | input | 1 | Frame sync pulse |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 1 | 0 selects the slot table, 1 selects the root map |
| wr_addr_i | input | 8 | Entry index or channel number |
| wr_data_i | input | 16 | Slot entry, or root channel in the low 8 bits |
| pop_o | output | 1 | Pop one byte from the selected FIFO |
| pop_ch_o | output | 8 | FIFO channel of the current entry |
| pop_root_o | output | 8 | Root channel owning the stream being popped |
| fifo_empty_i | input | 256 | Per-channel FIFO empty flags |
| fifo_data_i | input | 8 | Head byte of the FIFO named by `pop_ch_o` |
| underrun_o | output | 1 | Underrun pulse |
| underrun_ch_o | output | 8 | Channel that underran |
| tdm_tx_o | output | 1 | Serial TDM line data |
| tdm_loop_o | output | 1 | Serial data of loop entries |
| tdm_sync_o | output | 1 | Marks the first bit of a frame |

## Verification
A corrupted entry index or bit offset shows up at once as a wrong bit on `tdm_tx_o`. It also shows up later as a wrong number of pops per channel and a sync pulse that comes at the wrong time in the frame. A stale shift register changes the line within eight bits. A wrong root lookup is visible on `pop_root_o` in the same clock as the pop. Each frame is compared bit by bit against a bench model of the table and FIFOs, including the count of ones after the last entry. Per-channel pop and underrun totals are compared at the end of each frame.

// File: rtl/tdmseq_pkg.sv
package tdmseq_pkg;

    // One slot table entry; the bit positions follow the field layout in R1.
    typedef struct packed {
        logic       last;       // bit 15
        logic       byte_unit;  // bit 14
        logic [2:0] cnt;        // bits 13:11
        logic [7:0] ch;         // bits 10:3
        logic       sup;        // bit 2
        logic       loop;       // bit 1
        logic       en;         // bit 0
    } slot_entry_t;

    localparam int ENTRY_W = $bits(slot_entry_t);

    // Last bit offset inside an entry: (cnt+1)*8-1 for bytes, cnt for bits.
    function automatic logic [5:0] entry_last_off(slot_entry_t e);
        return e.byte_unit ? {e.cnt, 3'b111} : {3'b000, e.cnt};
    endfunction

endpackage

// File: rtl/tdmseq_slot_table.sv
module tdmseq_slot_table
    import tdmseq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  slot_entry_t      wr_entry_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output slot_entry_t      rd_entry_o
);

    slot_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_entry_i;
        end
    end

    assign rd_entry_o = mem_q[rd_idx_i];

endmodule

// File: rtl/tdmseq_root_map.sv
module tdmseq_root_map #(
    parameter int N_CH = 256,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            wr_en_i,
    input  logic [CH_W-1:0] wr_ch_i,
    input  logic [CH_W-1:0] wr_root_i,
    input  logic [CH_W-1:0] rd_ch_i,
    output logic [CH_W-1:0] rd_root_o
);

    logic [CH_W-1:0] map_q [N_CH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            map_q[wr_ch_i] <= wr_root_i;
        end
    end

    assign rd_root_o = map_q[rd_ch_i];

endmodule

// File: rtl/tdmseq_walker.sv
module tdmseq_walker
    import tdmseq_pkg::*;
#(
    parameter int N_CH  = 256,
    parameter int DEPTH = 64,
    parameter int CH_W  = $clog2(N_CH),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             fsync_i,
    input  slot_entry_t      entry_i,
    input  logic [CH_W-1:0]  root_i,
    input  logic [N_CH-1:0]  fifo_empty_i,
    input  logic [7:0]       fifo_data_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [CH_W-1:0]  ch_o,
    output logic             pop_o,
    output logic [CH_W-1:0]  pop_root_o,
    output logic             underrun_o,
    output logic [CH_W-1:0]  underrun_ch_o,
    output logic             tx_o,
    output logic             loop_o,
    output logic             sync_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic             run;
        logic [IDX_W-1:0] idx;
        logic [5:0]       boff;
        logic [7:0]       sh;
        logic             tx;
        logic             lp;
        logic             sync;
        logic             urun;
        logic [CH_W-1:0]  urun_ch;
    } walk_t;

    walk_t           st_d, st_q;
    logic            active;
    logic            pop;
    logic            bitv;
    logic [7:0]      octet;
    logic [5:0]      off_end;
    logic [CH_W-1:0] ch;

    always_comb begin
        st_d      = st_q;
        st_d.sync = 1'b0;
        st_d.urun = 1'b0;
        pop       = 1'b0;
        bitv      = 1'b1;
        octet     = 8'hFF;
        active    = st_q.run && enable_i;
        off_end   = entry_last_off(entry_i);
        ch        = entry_i.ch[CH_W-1:0];

        if (active) begin
            st_d.sync = (st_q.idx == '0) && (st_q.boff == '0);
            if (entry_i.en) begin
                if (st_q.boff[2:0] == 3'd0) begin
                    if (!fifo_empty_i[ch]) begin
                        pop   = 1'b1;
                        octet = fifo_data_i;
                    end else begin
                        st_d.urun    = 1'b1;
                        st_d.urun_ch = ch;
                    end
                    bitv    = octet[7];
                    st_d.sh = {octet[6:0], 1'b1};
                end else begin
                    bitv    = st_q.sh[7];
                    st_d.sh = {st_q.sh[6:0], 1'b1};
                end
            end
            if (st_q.boff == off_end) begin
                st_d.boff = '0;
                if (entry_i.last || (st_q.idx == LAST_IDX)) begin
                    st_d.run = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.boff = st_q.boff + 6'd1;
            end
        end

        st_d.tx = (active && !entry_i.loop) ? bitv : 1'b1;
        st_d.lp = (active &&  entry_i.loop) ? bitv : 1'b1;

        if (!enable_i) begin
            st_d.run = 1'b0;
        end
        if (fsync_i && enable_i) begin
            st_d.run  = 1'b1;
            st_d.idx  = '0;
            st_d.boff = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.tx <= 1'b1;
            st_q.lp <= 1'b1;
            st_q.sh <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o         = st_q.idx;
    assign ch_o          = ch;
    assign pop_o         = pop;
    assign pop_root_o    = entry_i.sup ? root_i : ch;
    assign underrun_o    = st_q.urun;
    assign underrun_ch_o = st_q.urun_ch;
    assign tx_o          = st_q.tx;
    assign loop_o        = st_q.lp;
    assign sync_o        = st_q.sync;

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
    import tdmseq_pkg::*;
#(
    parameter int N_CH      = 256,
    parameter int TBL_DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable_i,
    input  logic                     fsync_i,
    input  logic                     wr_en_i,
    input  logic                     wr_sel_i,
    input  logic [$clog2(N_CH)-1:0]  wr_addr_i,
    input  logic [ENTRY_W-1:0]       wr_data_i,
    output logic                     pop_o,
    output logic [$clog2(N_CH)-1:0]  pop_ch_o,
    output logic [$clog2(N_CH)-1:0]  pop_root_o,
    input  logic [N_CH-1:0]          fifo_empty_i,
    input  logic [7:0]               fifo_data_i,
    output logic                     underrun_o,
    output logic [$clog2(N_CH)-1:0]  underrun_ch_o,
    output logic                     tdm_tx_o,
    output logic                     tdm_loop_o,
    output logic                     tdm_sync_o
);

    localparam int CH_W  = $clog2(N_CH);
    localparam int IDX_W = $clog2(TBL_DEPTH);

    logic             tbl_we;
    logic             map_we;
    logic [IDX_W-1:0] rd_idx;
    slot_entry_t      cur_entry;
    logic [CH_W-1:0]  cur_ch;
    logic [CH_W-1:0]  cur_root;

    // Tables change only while stopped, so a frame never sees a half-written table.
    assign tbl_we = wr_en_i && !enable_i && !wr_sel_i && (int'(wr_addr_i) < TBL_DEPTH);
    assign map_we = wr_en_i && !enable_i &&  wr_sel_i;

    tdmseq_slot_table #(
        .DEPTH (TBL_DEPTH),
        .IDX_W (IDX_W)
    ) u_slot_table (
        .clk        (clk),
        .wr_en_i    (tbl_we),
        .wr_idx_i   (wr_addr_i[IDX_W-1:0]),
        .wr_entry_i (slot_entry_t'(wr_data_i)),
        .rd_idx_i   (rd_idx),
        .rd_entry_o (cur_entry)
    );

    tdmseq_root_map #(
        .N_CH (N_CH),
        .CH_W (CH_W)
    ) u_root_map (
        .clk       (clk),
        .wr_en_i   (map_we),
        .wr_ch_i   (wr_addr_i),
        .wr_root_i (wr_data_i[CH_W-1:0]),
        .rd_ch_i   (cur_ch),
        .rd_root_o (cur_root)
    );

    tdmseq_walker #(
        .N_CH  (N_CH),
        .DEPTH (TBL_DEPTH),
        .CH_W  (CH_W),
        .IDX_W (IDX_W)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .fsync_i       (fsync_i),
        .entry_i       (cur_entry),
        .root_i        (cur_root),
        .fifo_empty_i  (fifo_empty_i),
        .fifo_data_i   (fifo_data_i),
        .idx_o         (rd_idx),
        .ch_o          (cur_ch),
        .pop_o         (pop_o),
        .pop_root_o    (pop_root_o),
        .underrun_o    (underrun_o),
        .underrun_ch_o (underrun_ch_o),
        .tx_o          (tdm_tx_o),
        .loop_o        (tdm_loop_o),
        .sync_o        (tdm_sync_o)
    );

    assign pop_ch_o = cur_ch;

endmodule

// File: rtl/tdmseq_checks.sv
module tdmseq_checks #(
    parameter int N_CH = 256,
    parameter int CH_W = $clog2(N_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable_i,
    input logic            fsync_i,
    input logic            pop_o,
    input logic [CH_W-1:0] pop_ch_o,
    input logic [N_CH-1:0] fifo_empty_i,
    input logic            underrun_o,
    input logic            tdm_tx_o,
    input logic            tdm_loop_o,
    input logic            tdm_sync_o
);

    a_r7_pop_only_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> !fifo_empty_i[pop_ch_o]);

    a_r7_underrun_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> $past(!pop_o));

    a_r5_sync_follows_fsync: assert property (@(posedge clk) disable iff (!rst_n)
        tdm_sync_o |-> $past(fsync_i, 2));

    a_r9_no_pop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !pop_o);

    a_r9_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (tdm_tx_o && tdm_loop_o && !tdm_sync_o));

endmodule

bind tdm_slot_sequencer tdmseq_checks #(
    .N_CH (N_CH),
    .CH_W (CH_W)
) u_tdmseq_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .fsync_i      (fsync_i),
    .pop_o        (pop_o),
    .pop_ch_o     (pop_ch_o),
    .fifo_empty_i (fifo_empty_i),
    .underrun_o   (underrun_o),
    .tdm_tx_o     (tdm_tx_o),
    .tdm_loop_o   (tdm_loop_o),
    .tdm_sync_o   (tdm_sync_o)
);

// File: tb/test_tdm_slot_sequencer.sv
module test_tdm_slot_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 256;
    localparam int DEPTH      = 64;
    localparam int MAXB       = 4200;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            enable;
    logic            fsync;
    logic            wr_en;
    logic            wr_sel;
    logic [7:0]      wr_addr;
    logic [15:0]     wr_data;
    logic            pop;
    logic [7:0]      pop_ch;
    logic [7:0]      pop_root;
    logic [N_CH-1:0] fifo_empty;
    logic [7:0]      fifo_data;
    logic            urun;
    logic [7:0]      urun_ch;
    logic            tx;
    logic            lp;
    logic            sync;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_sequencer #(.N_CH(N_CH), .TBL_DEPTH(DEPTH)) i_tdm_slot_sequencer (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .fsync_i(fsync),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pop_o(pop), .pop_ch_o(pop_ch), .pop_root_o(pop_root),
        .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
        .underrun_o(urun), .underrun_ch_o(urun_ch),
        .tdm_tx_o(tx), .tdm_loop_o(lp), .tdm_sync_o(sync)
    );

    // ---------------- FIFO model (16-deep circular per channel) ----------------
    logic [7:0] fmem [N_CH][16];
    int         fcnt [N_CH];
    int         frd  [N_CH];

    always_comb begin
        for (int c = 0; c < N_CH; c++) fifo_empty[c] = (frd[c] >= fcnt[c]);
    end
    always_comb fifo_data = fmem[pop_ch][frd[pop_ch] % 16];
    always @(posedge clk) if (pop) frd[pop_ch] <= frd[pop_ch] + 1;

    // ---------------- observation logger ----------------
    int         pop_tot [N_CH];
    int         ur_tot  [N_CH];
    logic [7:0] root_log [8192];
    int         nroot;
    int         pops_all;
    always @(negedge clk) begin
        if (pop) begin
            pop_tot[pop_ch]++;
            root_log[nroot % 8192] = pop_root;
            nroot++;
            pops_all++;
        end
        if (urun) ur_tot[urun_ch]++;
    end

    // ---------------- bench copies and expectations ----------------
    logic [15:0] tb_tbl [DEPTH];
    logic [7:0]  tb_sct [N_CH];
    logic        exp_tx [MAXB];
    logic        exp_lp [MAXB];
    logic        act_tx [MAXB];
    logic        act_lp [MAXB];
    int          exp_pop [N_CH];
    int          exp_ur  [N_CH];
    int          efrd    [N_CH];
    int          pop0    [N_CH];
    int          ur0     [N_CH];
    logic [7:0]  exp_root [8192];
    int          n_exp_root;
    int          nroot0;
    int          model_bits;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(bit last, bit byt, int cnt, int ch,
                                        bit sup, bit loopb, bit en);
        return {last, byt, 3'(cnt), 8'(ch), sup, loopb, en};
    endfunction

    task automatic wr(input bit sel, input int addr, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = 8'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_tbl(input int idx, input logic [15:0] data);
        wr(1'b0, idx, data);
        tb_tbl[idx] = data;
    endtask

    task automatic put_map(input int ch, input int root);
        wr(1'b1, ch, 16'(root));
        tb_sct[ch] = 8'(root);
    endtask

    // Discard what is queued and load n bytes (call while no pops happen).
    task automatic fill(input int ch, input int n, input bit fixed, input logic [7:0] val);
        for (int i = 0; i < n; i++)
            fmem[ch][(frd[ch] + i) % 16] = fixed ? val : 8'($urandom);
        fcnt[ch] = frd[ch] + n;
    endtask

    // Expected line, loop, pops, underruns and roots from the requirements.
    task automatic build_expect();
        int pos;
        logic [7:0] octet;
        logic       b;
        pos = 0;
        n_exp_root = 0;
        for (int c = 0; c < N_CH; c++) begin
            efrd[c] = frd[c]; exp_pop[c] = 0; exp_ur[c] = 0;
        end
        octet = 8'hFF;
        for (int e = 0; e < DEPTH; e++) begin
            logic [15:0] t;
            int len, ch;
            t   = tb_tbl[e];
            len = t[14] ? (int'(t[13:11]) + 1) * 8 : int'(t[13:11]) + 1;   // R1
            ch  = int'(t[10:3]);
            for (int k = 0; k < len; k++) begin
                if (t[0]) begin
                    if (k % 8 == 0) begin
                        if (efrd[ch] < fcnt[ch]) begin
                            octet = fmem[ch][efrd[ch] % 16];
                            efrd[ch]++;
                            exp_pop[ch]++;
                            exp_root[n_exp_root] = t[2] ? tb_sct[ch] : 8'(ch);
                            n_exp_root++;
                        end else begin
                            octet = 8'hFF;
                            exp_ur[ch]++;
                        end
                    end
                    b = octet[7 - (k % 8)];
                end else begin
                    b = 1'b1;                                            // R3
                end
                exp_tx[pos] = t[1] ? 1'b1 : b;                          // R12
                exp_lp[pos] = t[1] ? b : 1'b1;
                pos++;
            end
            if (t[15]) break;                                            // R4
        end
        model_bits = pos;
    endtask

    // Pulse sync, collect one frame plus an idle tail, compare.
    task automatic run_frame(input string tag);
        int nbits, bad_tx, bad_lp, bad_pop, bad_ur, bad_root, nsync;
        build_expect();
        nbits = model_bits + 8;
        for (int i = model_bits; i < nbits; i++) begin
            exp_tx[i] = 1'b1; exp_lp[i] = 1'b1;
        end
        @(negedge clk);
        for (int c = 0; c < N_CH; c++) begin pop0[c] = pop_tot[c]; ur0[c] = ur_tot[c]; end
        nroot0 = nroot;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        @(negedge clk);
        check(sync === 1'b1, "R5", {tag, " sync on first bit"}, int'(sync), 1);
        nsync = 0;
        for (int i = 0; i < nbits; i++) begin
            act_tx[i] = tx; act_lp[i] = lp;
            if (sync) nsync++;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        bad_tx = 0; bad_lp = 0;
        for (int i = 0; i < nbits; i++) begin
            if (act_tx[i] !== exp_tx[i]) bad_tx++;
            if (act_lp[i] !== exp_lp[i]) bad_lp++;
        end
        check(bad_tx == 0, "R2", {tag, " line bit mismatches"}, bad_tx, 0);
        check(bad_lp == 0, "R12", {tag, " loop bit mismatches"}, bad_lp, 0);
        check(nsync == 1, "R4", {tag, " sync pulses in frame"}, nsync, 1);
        bad_pop = 0; bad_ur = 0;
        for (int c = 0; c < N_CH; c++) begin
            if (pop_tot[c] - pop0[c] != exp_pop[c]) bad_pop++;
            if (ur_tot[c] - ur0[c] != exp_ur[c]) bad_ur++;
        end
        check(bad_pop == 0, "R2", {tag, " channels with wrong pop count"}, bad_pop, 0);
        check(bad_ur == 0, "R7", {tag, " channels with wrong underrun count"}, bad_ur, 0);
        bad_root = (nroot - nroot0 != n_exp_root) ? 1 : 0;
        for (int i = 0; i < n_exp_root && bad_root == 0; i++)
            if (root_log[(nroot0 + i) % 8192] !== exp_root[i]) bad_root++;
        check(bad_root == 0, "R6", {tag, " root sequence"}, nroot - nroot0, n_exp_root);
    endtask

    task automatic stop_walk();
        @(negedge clk); enable = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); enable = 1'b1;
    endtask

    initial begin
        int seed_dummy;
        int p0, bad;
        seed_dummy = $urandom(32'd4711);
        rst_n = 1'b0; enable = 1'b0; fsync = 1'b0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(tx === 1'b1, "R10", "line after reset", int'(tx), 1);
        check(lp === 1'b1, "R10", "loop after reset", int'(lp), 1);
        check(sync === 1'b0 && pop === 1'b0 && urun === 1'b0, "R10",
              "sync/pop/underrun after reset", int'({sync, pop, urun}), 0);

        for (int c = 0; c < N_CH; c++) put_map(c, c);

        // Directed: 30-octet payload style frame, R11 and R3 and R6
        put_tbl(0, enc(0, 1, 0, 0, 0, 0, 0));
        for (int e = 1; e <= 7; e++) put_tbl(e, enc(0, 1, 1, e, 1, 0, 1));
        put_tbl(8, enc(1, 1, 0, 8, 1, 0, 1));
        for (int c = 1; c <= 8; c++) put_map(c, 2);
        for (int c = 1; c <= 7; c++) fill(c, 2, 0, 8'h00);
        fill(8, 1, 0, 8'h00);
        go();
        run_frame("payload");
        check(pop_tot[1] - pop0[1] == 2, "R11", "two bytes from one FIFO", pop_tot[1] - pop0[1], 2);
        bad = 0;
        for (int i = 0; i < 8; i++) if (act_tx[i] !== 1'b1) bad++;
        check(bad == 0, "R3", "unsourced slot not all ones", bad, 0);

        // Directed R7: second byte of a 2-byte entry finds the FIFO empty
        stop_walk();
        put_tbl(0, enc(1, 1, 1, 3, 0, 0, 1));
        fill(3, 1, 1, 8'h3C);
        go();
        run_frame("underrun");
        check(ur_tot[3] - ur0[3] == 1, "R7", "underrun count ch3", ur_tot[3] - ur0[3], 1);

        // Directed R8: writes while enabled change nothing
        stop_walk();
        put_tbl(0, enc(1, 1, 0, 2, 1, 0, 1));
        fill(2, 1, 1, 8'h96);
        go();
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 8'd0; wr_data = enc(1, 1, 0, 5, 0, 0, 0);
        @(negedge clk); wr_sel = 1'b1; wr_addr = 8'd2; wr_data = 16'd9;
        @(negedge clk); wr_en = 1'b0;
        run_frame("R8 write while enabled");

        // Directed R5: sync in mid-walk restarts at entry 0
        stop_walk();
        put_tbl(0, enc(0, 1, 0, 0, 0, 0, 1));
        put_tbl(1, enc(1, 1, 7, 0, 0, 0, 0));
        fill(0, 16, 1, 8'hA5);
        go();
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        repeat (30) @(negedge clk);
        run_frame("R5 restart");

        // Directed R9: disable in mid-frame, re-enable without sync
        stop_walk();
        put_tbl(0, enc(1, 1, 7, 0, 0, 0, 1));
        fill(0, 8, 0, 8'h00);
        go();
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        repeat (20) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        p0 = pops_all; bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (tx !== 1'b1 || lp !== 1'b1 || sync !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0 && pops_all == p0, "R9", "activity while disabled", bad + pops_all - p0, 0);
        enable = 1'b1;
        @(negedge clk);
        p0 = pops_all; bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (tx !== 1'b1 || sync !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0 && pops_all == p0, "R9", "walk resumed without sync", bad + pops_all - p0, 0);

        // Random tables (R1 R2 R3 R4 R6 R7 R12)
        for (int f = 0; f < 25; f++) begin
            int n;
            stop_walk();
            n = 1 + int'($urandom % 10);
            for (int e = 0; e < n; e++)
                put_tbl(e, enc(e == n - 1, ($urandom % 3) != 0, int'($urandom % 8),
                               int'($urandom % 8), $urandom % 2, ($urandom % 5) == 0,
                               ($urandom % 4) != 0));
            for (int c = 0; c < 8; c++) put_map(c, int'($urandom % 256));
            for (int c = 0; c < 8; c++) fill(c, int'($urandom % 9), 0, 8'h00);
            go();
            run_frame("random R1");
            run_frame("random repeat");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL R4 watchdog: actual=timeout expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule